// File: doc/BRIEF.md
# Switch Channel Fault Configuration and Overcurrent Latch

This block holds the protection settings for a twelve-channel power switch. Channels 0 to 3 are high-side drivers and channels 4 to 11 are low-side drivers. A host writes two configuration registers over a narrow register port, and the block drives the per-channel controls that the analog front end consumes. The first register decides which channels sense an open load while they are off. The second register chooses between the peak and sustain current-limit level on each high-side channel. It also arms overcurrent latch-off on each low-side channel.

For an armed low-side channel, the block times the overcurrent comparator flag in clock cycles. If the flag persists for a full programmable delay, the block latches that channel off. The latch holds until the host writes a 0 to the channel's bit in the switch-output register, or until reset. Open-load comparator flags are filtered. A flag is reported only for a channel that is off and has detection enabled.

Top module: `fault_cfg_latch`

## Requirements
- R1: On synchronous reset, ol_det_en is 0x00F (high-side detection on, low-side off), lim_sustain is 0, ls_off is 0 and ol_fault is 0.
- R2: A write to address 3'b100 sets ol_det_en[i] = ~wr_data[i] for i in 0..3, visible the cycle after the write.
- R3: A write to address 3'b100 sets ol_det_en[i] = wr_data[i] for i in 4..11, visible the cycle after the write.
- R4: A write to address 3'b101 sets lim_sustain[3:0] = wr_data[3:0] (1 selects the sustain level), visible the cycle after the write.
- R5: A write to address 3'b101 arms latch-off of low-side channel j (ls_off[j], oc_flag[j]) with wr_data[4+j]. An unarmed channel never latches, whatever its overcurrent flag does.
- R6: An armed channel whose oc_flag is sampled high on FLT_DLY_CYC consecutive clock edges shows ls_off high after the last of those edges, and not after FLT_DLY_CYC-1 edges.
- R7: If oc_flag drops for one sampled cycle before the delay expires, the count restarts from zero.
- R8: A set ls_off[j] clears only on reset or on a write to address 3'b000 with wr_data[4+j] = 0. Such a write with wr_data[4+j] = 1 leaves it set.
- R9: ol_fault[i] is the registered value of ol_flag[i] AND NOT chan_on[i] AND ol_det_en[i], one cycle after the inputs.
- R10: Writes to addresses other than 3'b100 and 3'b101 leave ol_det_en and lim_sustain unchanged.
- R11: Once ls_off[j] is set, dropping oc_flag[j] or disarming the channel does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 12 | Write data, bit i belongs to channel i |
| chan_on | input | 12 | Current on/off state of each channel |
| ol_flag | input | 12 | Open-load comparator flag per channel |
| oc_flag | input | 8 | Overcurrent comparator flag per low-side channel |
| ol_det_en | output | 12 | Off-state open-load detection enable per channel |
| lim_sustain | output | 4 | High-side current-limit select, 1 = sustain level |
| ls_off | output | 8 | Latched overcurrent shutdown per low-side channel |
| ol_fault | output | 12 | Filtered open-load fault status per channel |

## Verification
On every cycle, the assertions check the following. The configuration outputs hold still when their register is not addressed. A set shutdown latch survives everything but its release write, and that write always clears it. A latch rises only after an armed, flagged cycle. A reported open-load fault always traces back to an off, enabled and flagged channel. The exact delay length, the restart of the count after a dropped flag, the polarity split between the channel groups, and the inertness of the unused addresses are shown only by the bench scenarios. Each of those scenarios compares cycle-exact output values against expectations.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SWITCH = 3'b000;
  localparam logic [ADDR_W-1:0] A_OLCFG  = 3'b100;
  localparam logic [ADDR_W-1:0] A_LIMCFG = 3'b101;

  typedef enum logic [1:0] {
    OC_CLEAR  = 2'd0,
    OC_TIMING = 2'd1,
    OC_OFF    = 2'd2
  } oc_state_e;
endpackage

// File: rtl/fcl_cfg_regs.sv
module fcl_cfg_regs
  import fcl_pkg::*;
#(
  parameter int N_HS = 4,
  parameter int N_LS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [N_HS+N_LS-1:0]  wr_data,
  output logic [N_HS+N_LS-1:0]  det_en_q,
  output logic [N_HS-1:0]       lim_q,
  output logic [N_LS-1:0]       oc_en_q,
  output logic [N_LS-1:0]       release_o
);
  localparam int NCH = N_HS + N_LS;
  // high-side bits are stored inverted so the register holds enables directly
  localparam logic [NCH-1:0] POL_MASK = {{N_LS{1'b0}}, {N_HS{1'b1}}};

  logic wr_ol, wr_lim, wr_sw;

  always_comb begin
    wr_ol  = wr_en && (wr_addr == A_OLCFG);
    wr_lim = wr_en && (wr_addr == A_LIMCFG);
    wr_sw  = wr_en && (wr_addr == A_SWITCH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_en_q <= POL_MASK;
      lim_q    <= '0;
      oc_en_q  <= '0;
    end else begin
      if (wr_ol) begin
        det_en_q <= wr_data ^ POL_MASK;
      end
      if (wr_lim) begin
        lim_q   <= wr_data[N_HS-1:0];
        oc_en_q <= wr_data[N_HS +: N_LS];
      end
    end
  end

  always_comb begin
    release_o = {N_LS{wr_sw}} & ~wr_data[N_HS +: N_LS];
  end
endmodule

// File: rtl/fcl_oc_latch.sv
module fcl_oc_latch
  import fcl_pkg::*;
#(
  parameter int FLT_DLY_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_flag,
  input  logic oc_en,
  input  logic release_i,
  output logic off_q
);
  localparam int CW = $clog2(FLT_DLY_CYC) + 1;
  localparam logic [CW-1:0] LAST = CW'(FLT_DLY_CYC - 1);

  oc_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          hit;

  always_comb hit = oc_flag && oc_en;

  always_ff @(posedge clk) begin
    if (rst || release_i) begin
      st_q  <= OC_CLEAR;
      cnt_q <= '0;
      off_q <= 1'b0;
    end else begin
      unique case (st_q)
        OC_CLEAR: begin
          if (hit) begin
            if (LAST == '0) begin
              st_q  <= OC_OFF;
              off_q <= 1'b1;
              cnt_q <= '0;
            end else begin
              st_q  <= OC_TIMING;
              cnt_q <= CW'(1);
            end
          end
        end
        OC_TIMING: begin
          if (!hit) begin
            st_q  <= OC_CLEAR;
            cnt_q <= '0;
          end else if (cnt_q == LAST) begin
            st_q  <= OC_OFF;
            off_q <= 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        OC_OFF: begin
          off_q <= 1'b1;
        end
        default: begin
          st_q  <= OC_CLEAR;
          cnt_q <= '0;
          off_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fcl_ol_report.sv
module fcl_ol_report #(
  parameter int NCH = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ol_flag,
  input  logic [NCH-1:0] chan_on,
  input  logic [NCH-1:0] det_en,
  output logic [NCH-1:0] fault_q
);
  always_ff @(posedge clk) begin
    if (rst) fault_q <= '0;
    else     fault_q <= ol_flag & ~chan_on & det_en;
  end
endmodule

// File: rtl/fault_cfg_latch.sv
module fault_cfg_latch
  import fcl_pkg::*;
#(
  parameter int N_HS        = 4,
  parameter int N_LS        = 8,
  parameter int FLT_DLY_CYC = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [N_HS+N_LS-1:0]  wr_data,
  input  logic [N_HS+N_LS-1:0]  chan_on,
  input  logic [N_HS+N_LS-1:0]  ol_flag,
  input  logic [N_LS-1:0]       oc_flag,
  output logic [N_HS+N_LS-1:0]  ol_det_en,
  output logic [N_HS-1:0]       lim_sustain,
  output logic [N_LS-1:0]       ls_off,
  output logic [N_HS+N_LS-1:0]  ol_fault
);
  localparam int NCH = N_HS + N_LS;

  logic [N_LS-1:0] oc_en_q;
  logic [N_LS-1:0] release_w;

  fcl_cfg_regs #(.N_HS(N_HS), .N_LS(N_LS)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .det_en_q(ol_det_en), .lim_q(lim_sustain), .oc_en_q(oc_en_q),
    .release_o(release_w)
  );

  for (genvar j = 0; j < N_LS; j++) begin : g_ls
    fcl_oc_latch #(.FLT_DLY_CYC(FLT_DLY_CYC)) latch_i (
      .clk(clk), .rst(rst), .oc_flag(oc_flag[j]), .oc_en(oc_en_q[j]),
      .release_i(release_w[j]), .off_q(ls_off[j])
    );
  end

  fcl_ol_report #(.NCH(NCH)) olr_i (
    .clk(clk), .rst(rst), .ol_flag(ol_flag), .chan_on(chan_on),
    .det_en(ol_det_en), .fault_q(ol_fault)
  );
endmodule

// File: rtl/fault_cfg_latch_chk.sv
module fault_cfg_latch_chk
  import fcl_pkg::*;
#(
  parameter int N_HS = 4,
  parameter int N_LS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [2:0]           wr_addr,
  input logic [N_LS-1:0]      rel_bits,
  input logic [N_HS+N_LS-1:0] chan_on,
  input logic [N_HS+N_LS-1:0] ol_flag,
  input logic [N_LS-1:0]      oc_flag,
  input logic [N_LS-1:0]      oc_en,
  input logic [N_HS+N_LS-1:0] ol_det_en,
  input logic [N_HS-1:0]      lim_sustain,
  input logic [N_LS-1:0]      ls_off,
  input logic [N_HS+N_LS-1:0] ol_fault
);
  AST_OLCFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_OLCFG) |=> $stable(ol_det_en)); // R10

  AST_LIMCFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_LIMCFG) |=> $stable(lim_sustain)); // R4

  for (genvar j = 0; j < N_LS; j++) begin : g_ls
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
      ls_off[j] && !(wr_en && wr_addr == A_SWITCH && !rel_bits[j]) |=> ls_off[j]); // R11

    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_addr == A_SWITCH && !rel_bits[j] |=> !ls_off[j]); // R8

    AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(ls_off[j]) |-> $past(oc_flag[j] && oc_en[j])); // R5
  end

  for (genvar i = 0; i < N_HS + N_LS; i++) begin : g_ch
    AST_OLF_SOURCE: assert property (@(posedge clk) disable iff (rst)
      ol_fault[i] |-> $past(ol_flag[i] && !chan_on[i] && ol_det_en[i])); // R9
  end
endmodule

bind fault_cfg_latch fault_cfg_latch_chk #(.N_HS(N_HS), .N_LS(N_LS)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .rel_bits(wr_data[N_HS +: N_LS]), .chan_on(chan_on), .ol_flag(ol_flag),
  .oc_flag(oc_flag), .oc_en(oc_en_q), .ol_det_en(ol_det_en),
  .lim_sustain(lim_sustain), .ls_off(ls_off), .ol_fault(ol_fault)
);

// File: tb/fault_cfg_latch_tb_top.sv
module fault_cfg_latch_tb_top;
  localparam int DLY = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [11:0] chan_on = '0;
  logic [11:0] ol_flag = '0;
  logic [7:0]  oc_flag = '0;
  logic [11:0] ol_det_en;
  logic [3:0]  lim_sustain;
  logic [7:0]  ls_off;
  logic [11:0] ol_fault;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fault_cfg_latch #(.N_HS(4), .N_LS(8), .FLT_DLY_CYC(DLY)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chan_on(chan_on), .ol_flag(ol_flag), .oc_flag(oc_flag),
    .ol_det_en(ol_det_en), .lim_sustain(lim_sustain), .ls_off(ls_off),
    .ol_fault(ol_fault)
  );

  // {addr, data, expected ol_det_en, expected lim_sustain}
  localparam logic [30:0] VEC [8] = '{
    {3'b100, 12'h005, 12'h00A, 4'h0},  // R2
    {3'b100, 12'hAF0, 12'hAFF, 4'h0},  // R3
    {3'b101, 12'h009, 12'hAFF, 4'h9},  // R4
    {3'b110, 12'hFFF, 12'hAFF, 4'h9},  // R10
    {3'b011, 12'h000, 12'hAFF, 4'h9},  // R10
    {3'b100, 12'h000, 12'h00F, 4'h9},  // R2 R3
    {3'b101, 12'hFF6, 12'h00F, 4'h6},  // R4 R5
    {3'b111, 12'h000, 12'h00F, 4'h6}   // R10
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    failures++; checks++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    chk("R1 det", 32'(ol_det_en), 32'h00F);
    chk("R1 lim", 32'(lim_sustain), 32'h0);
    chk("R1 off", 32'(ls_off), 32'h0);
    chk("R1 olf", 32'(ol_fault), 32'h0);

    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][30:28], VEC[v][27:16]);
      chk($sformatf("R2/R3/R4/R10 vec%0d det", v), 32'(ol_det_en), 32'(VEC[v][15:4]));
      chk($sformatf("R4/R10 vec%0d lim", v), 32'(lim_sustain), 32'(VEC[v][3:0]));
    end

    // R6: all low-side armed now; delay on channel 4 (ls_off[0])
    @(negedge clk); oc_flag[0] = 1'b1;
    cyc(DLY - 1);
    chk("R6 not yet", 32'(ls_off[0]), 32'h0);
    cyc(1);
    chk("R6 latched", 32'(ls_off[0]), 32'h1);

    // R11: drop flag and disarm, latch holds
    oc_flag[0] = 1'b0;
    cyc(3);
    chk("R11 flag drop", 32'(ls_off[0]), 32'h1);
    wr(3'b101, 12'h006);
    cyc(2);
    chk("R11 disarm", 32'(ls_off[0]), 32'h1);

    // R8: write 1 keeps, write 0 releases
    wr(3'b000, 12'hFFF);
    chk("R8 write one", 32'(ls_off[0]), 32'h1);
    wr(3'b000, 12'h000);
    chk("R8 release", 32'(ls_off[0]), 32'h0);

    // R5: unarmed channel never latches
    oc_flag[1] = 1'b1;
    cyc(3 * DLY);
    chk("R5 unarmed", 32'(ls_off), 32'h0);
    oc_flag[1] = 1'b0;

    // R7: gap restarts the count
    wr(3'b101, 12'hFF0);
    @(negedge clk); oc_flag[2] = 1'b1;
    cyc(DLY - 1);
    oc_flag[2] = 1'b0;
    cyc(1);
    oc_flag[2] = 1'b1;
    cyc(DLY - 1);
    chk("R7 restarted", 32'(ls_off[2]), 32'h0);
    cyc(1);
    chk("R7 latched", 32'(ls_off), 32'h04);
    oc_flag[2] = 1'b0;
    wr(3'b000, 12'h000);
    chk("R8 release ch6", 32'(ls_off), 32'h0);

    // R9: open-load reporting filter
    wr(3'b100, 12'h010);
    chk("R3 det ch4", 32'(ol_det_en), 32'h01F);
    ol_flag = 12'hFFF; chan_on = 12'h000;
    cyc(1);
    chk("R9 off enabled", 32'(ol_fault), 32'h01F);
    chan_on = 12'h003;
    cyc(1);
    chk("R9 on masks", 32'(ol_fault), 32'h01C);
    ol_flag = 12'h000;
    cyc(1);
    chk("R9 no flag", 32'(ol_fault), 32'h000);

    // R1: reset clears a latch and the registers mid-run
    oc_flag[3] = 1'b1;
    cyc(DLY + 1);
    chk("R6 ch7 latched", 32'(ls_off), 32'h08);
    oc_flag[3] = 1'b0;
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    chk("R1 off after rst", 32'(ls_off), 32'h0);
    chk("R1 det after rst", 32'(ol_det_en), 32'h00F);
    chk("R1 lim after rst", 32'(lim_sustain), 32'h0);
    // reset left latch-off unarmed
    oc_flag = 8'hFF;
    cyc(2 * DLY);
    chk("R5 unarmed after rst", 32'(ls_off), 32'h0);
    oc_flag = 8'h00;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule